// File: doc/BRIEF.md
# Dual-Strobe Reversible Binary Counter

This block keeps a binary count that two separate strobes move. A rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. Both strobes rest high when idle, and only one of them is pulsed at a time. A parallel word can be preset into the count through an active-low load. An active-high clear resets the count to zero at once and takes priority over every other input.

The strobes are not treated as clocks. One fast system clock oversamples them through a synchronizer, and rising edges are found by comparing the synchronized level with the level held one cycle earlier.

Two active-low terminal outputs repeat the low phase of the active strobe, but only while the count sits at its top value (up direction) or at zero (down direction). Each one can therefore drive a strobe input of the next stage in a chain. If one strobe rises while the other is low, the count is left alone and a one-cycle error pulse is raised.

Top module: `updown_strobe_counter`

## Requirements
- R1: While `clr` is high, `count` is 0 and `err` is 0, whatever `load_n`, `data` and the strobes do. Raising `clr` between clock edges zeroes `count` before the next edge.
- R2: With `dn_strb` held high, each rising edge of `up_strb` raises `count` by exactly one, and 15 wraps to 0. The new value appears on the third system-clock rising edge after the strobe rises.
- R3: With `up_strb` held high, each rising edge of `dn_strb` lowers `count` by exactly one, and 0 wraps to 15.
- R4: With `clr` low, a low `load_n` at a clock edge copies `data` into `count`. Strobe edges that arrive while `load_n` is low leave `count` and `err` unchanged.
- R5: `tc_up_n` is low exactly when `count` is 15 and the synchronized up strobe is low. At all other times it is high.
- R6: `tc_dn_n` is low exactly when `count` is 0 and the synchronized down strobe is low. At all other times it is high.
- R7: Suppose a strobe is held low through a clear or a load and then rises after the clear or load has been released. That rise is counted as a valid step.
- R8: Suppose one strobe rises while the other is low, or both rise in the same cycle. Then `err` is high for one system cycle and `count` keeps its value.
- R9: Releasing `clr` or `load_n` with both strobes resting high never creates a count step or an error pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the strobes |
| clr | input | 1 | Asynchronous clear, active high |
| load_n | input | 1 | Synchronous parallel preset, active low |
| up_strb | input | 1 | Count-up strobe, idle high, acts on rising edge |
| dn_strb | input | 1 | Count-down strobe, idle high, acts on rising edge |
| data | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| tc_up_n | output | 1 | Low copy of the up strobe while the count is at its maximum |
| tc_dn_n | output | 1 | Low copy of the down strobe while the count is zero |
| err | output | 1 | One-cycle pulse on strobe misuse |

## Verification
The assertions assume that `load_n` and `data` are synchronous to `clk`. They also assume that every strobe level stays put long enough for the synchronizer to carry it through. With those assumptions, a step in `count` can only come from a single counted edge or a load. The stimulus holds every strobe level and every change of clear or load for four system cycles. Strobe changes are placed only at falling clock edges, so no level is shorter than the synchronizer depth. The misuse case is produced on purpose by dropping the down strobe and then pulsing the up strobe while the down strobe is still low.

// File: rtl/usc_pkg.sv
package usc_pkg;
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_UP   = 2'd2,
      OP_DOWN = 2'd3
   } usc_op_e;
endpackage

// File: rtl/usc_sync.sv
module usc_sync #(
   parameter int N      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("usc_sync: STAGES must be at least 2");
   end

   logic [N-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) stg[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/usc_decode.sv
module usc_decode
   import usc_pkg::*;
(
   input  logic    clk,
   input  logic    load_n,
   input  logic    up_s,
   input  logic    dn_s,
   output usc_op_e op,
   output logic    misuse
);
   // History is left without reset on purpose: it follows the synchronized
   // levels during clear and load, so leaving either never looks like an edge.
   logic up_p, dn_p;
   always_ff @(posedge clk) begin
      up_p <= up_s;
      dn_p <= dn_s;
   end

   logic up_rise, dn_rise, up_ok, dn_ok;
   assign up_rise = up_s & ~up_p;
   assign dn_rise = dn_s & ~dn_p;
   assign up_ok   = up_rise & dn_s & ~dn_rise;
   assign dn_ok   = dn_rise & up_s & ~up_rise;

   always_comb begin
      misuse = 1'b0;
      if (!load_n)    op = OP_LOAD;
      else if (up_ok) op = OP_UP;
      else if (dn_ok) op = OP_DOWN;
      else begin
         op     = OP_HOLD;
         misuse = up_rise | dn_rise;
      end
   end
endmodule

// File: rtl/usc_core.sv
module usc_core
   import usc_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr,
   input  usc_op_e          op,
   input  logic             misuse,
   input  logic [WIDTH-1:0] data,
   output logic [WIDTH-1:0] cnt,
   output logic             err
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         cnt <= '0;
         err <= 1'b0;
      end else begin
         unique case (op)
            OP_LOAD: cnt <= data;
            OP_UP:   cnt <= cnt + ONE;
            OP_DOWN: cnt <= cnt - ONE;
            default: cnt <= cnt;
         endcase
         err <= misuse;
      end
   end
endmodule

// File: rtl/updown_strobe_counter.sv
module updown_strobe_counter
   import usc_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             load_n,
   input  logic             up_strb,
   input  logic             dn_strb,
   input  logic [WIDTH-1:0] data,
   output logic [WIDTH-1:0] count,
   output logic             tc_up_n,
   output logic             tc_dn_n,
   output logic             err
);
   if (WIDTH < 1) begin : g_bad_width
      $error("updown_strobe_counter: WIDTH must be positive");
   end

   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   logic [1:0] strb_s;
   logic       up_s, dn_s, misuse;
   usc_op_e    op;

   usc_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   ({up_strb, dn_strb}),
      .q   (strb_s)
   );
   assign up_s = strb_s[1];
   assign dn_s = strb_s[0];

   usc_decode u_dec (
      .clk    (clk),
      .load_n (load_n),
      .up_s   (up_s),
      .dn_s   (dn_s),
      .op     (op),
      .misuse (misuse)
   );

   usc_core #(.WIDTH(WIDTH)) u_core (
      .clk    (clk),
      .clr    (clr),
      .op     (op),
      .misuse (misuse),
      .data   (data),
      .cnt    (count),
      .err    (err)
   );

   // Terminal outputs follow the synchronized strobe so they stay aligned
   // with the count register that they are gated by.
   assign tc_up_n = ~((count == TOP) & ~up_s);
   assign tc_dn_n = ~((count == '0) & ~dn_s);
endmodule

// File: rtl/usc_checker.sv
module usc_checker #(
   parameter int WIDTH = 4
) (
   input logic             clk,
   input logic             clr,
   input logic             load_n,
   input logic [WIDTH-1:0] data,
   input logic [WIDTH-1:0] count,
   input logic             tc_up_n,
   input logic             tc_dn_n,
   input logic             err
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   a_r1_clear_forces_zero: assert property (@(posedge clk)
      clr |-> (count == '0) && !err);

   a_r4_load_takes_data: assert property (@(posedge clk) disable iff (clr)
      !load_n |=> count == $past(data));

   a_r2_r3_single_step: assert property (@(posedge clk) disable iff (clr)
      ($past(load_n) && (count != $past(count))) |->
         ((count == WIDTH'($past(count) + ONE)) ||
          (count == WIDTH'($past(count) - ONE))));

   a_r8_misuse_holds_count: assert property (@(posedge clk) disable iff (clr)
      err |-> count == $past(count));

   a_r5_tcu_only_at_top: assert property (@(posedge clk) disable iff (clr)
      !tc_up_n |-> count == TOP);

   a_r6_tcd_only_at_zero: assert property (@(posedge clk) disable iff (clr)
      !tc_dn_n |-> count == '0);
endmodule

bind updown_strobe_counter usc_checker #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .clr     (clr),
   .load_n  (load_n),
   .data    (data),
   .count   (count),
   .tc_up_n (tc_up_n),
   .tc_dn_n (tc_dn_n),
   .err     (err)
);

// File: tb/tb_updown_strobe_counter.sv
module tb_updown_strobe_counter;
   logic       clk = 1'b0;
   logic       clr = 1'b1;
   logic       load_n = 1'b1;
   logic       up = 1'b1;
   logic       dn = 1'b1;
   logic [3:0] data = 4'd0;
   logic [3:0] count;
   logic       tc_up_n, tc_dn_n, err;

   always #5 clk = ~clk;

   updown_strobe_counter dut (
      .clk(clk), .clr(clr), .load_n(load_n), .up_strb(up), .dn_strb(dn),
      .data(data), .count(count), .tc_up_n(tc_up_n), .tc_dn_n(tc_dn_n),
      .err(err)
   );

   int checks = 0;
   int errors = 0;
   int err_seen = 0;
   int m_err = 0;
   logic [3:0] m_cnt = 4'd0;

   typedef struct {
      string      tag;
      logic [3:0] cnt;
      logic       tcu;
      logic       tcd;
      int         errs;
   } item_t;
   item_t sb[$];
   item_t it;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_now(string tag);
      item_t e;
      e.tag  = tag;
      e.cnt  = m_cnt;
      e.tcu  = !(m_cnt == 4'd15 && up == 1'b0);
      e.tcd  = !(m_cnt == 4'd0 && dn == 1'b0);
      e.errs = m_err;
      sb.push_back(e);
      @(negedge clk);
   endtask

   task automatic set_up(logic v);
      @(negedge clk);
      if (v && !up && !clr && load_n) begin
         if (dn) m_cnt = m_cnt + 4'd1;
         else    m_err++;
      end
      up = v;
      settle();
   endtask

   task automatic set_dn(logic v);
      @(negedge clk);
      if (v && !dn && !clr && load_n) begin
         if (up) m_cnt = m_cnt - 4'd1;
         else    m_err++;
      end
      dn = v;
      settle();
   endtask

   task automatic set_load(logic v, logic [3:0] d);
      @(negedge clk);
      data   = d;
      load_n = v;
      if (!v && !clr) m_cnt = d;
      settle();
   endtask

   task automatic set_clr(logic v);
      @(negedge clk);
      clr = v;
      if (v) m_cnt = 4'd0;
      settle();
   endtask

   // error pulse counter, sampled away from the active edge
   always @(negedge clk) if (err === 1'b1) err_seen++;

   // scoreboard monitor
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         it = sb.pop_front();
         chk({it.tag, " count"},   int'(count),   int'(it.cnt));
         chk({it.tag, " tc_up_n"}, int'(tc_up_n), int'(it.tcu));
         chk({it.tag, " tc_dn_n"}, int'(tc_dn_n), int'(it.tcd));
         chk({it.tag, " err"},     err_seen,      it.errs);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state, clear overrides load
      settle();
      expect_now("R1 reset");
      set_load(1'b0, 4'd9);
      expect_now("R1 clear beats load");
      set_load(1'b1, 4'd9);
      // R9: leaving clear with idle strobes
      set_clr(1'b0);
      expect_now("R9 clear release");
      // R6 and R3 wrap
      set_dn(1'b0);
      expect_now("R6 tcd low at zero");
      set_dn(1'b1);
      expect_now("R3 wrap 0 to 15");
      // R5 and R2 wrap
      set_up(1'b0);
      expect_now("R5 tcu low at top");
      set_up(1'b1);
      expect_now("R2 wrap 15 to 0");
      // R2/R3 plain steps
      for (int i = 0; i < 3; i++) begin
         set_up(1'b0);
         set_up(1'b1);
      end
      expect_now("R2 three ups");
      set_dn(1'b0);
      set_dn(1'b1);
      expect_now("R3 one down");
      // R4: load with strobe edges ignored
      set_load(1'b0, 4'd10);
      set_up(1'b0);
      set_up(1'b1);
      expect_now("R4 load ignores strobe");
      set_load(1'b1, 4'd10);
      expect_now("R9 load release");
      // R7: strobe low across load
      set_up(1'b0);
      set_load(1'b0, 4'd5);
      set_load(1'b1, 4'd5);
      expect_now("R7 load with up low");
      set_up(1'b1);
      expect_now("R7 up after load");
      // R7: strobe low across clear
      set_dn(1'b0);
      set_clr(1'b1);
      set_clr(1'b0);
      expect_now("R7 clear with dn low");
      set_dn(1'b1);
      expect_now("R7 dn after clear");
      // R8: misuse
      set_dn(1'b0);
      set_up(1'b0);
      set_up(1'b1);
      expect_now("R8 misuse flagged");
      set_dn(1'b1);
      expect_now("R3 down after misuse");
      // R1: asynchronous clear between edges
      @(negedge clk);
      #2 clr = 1'b1;
      m_cnt = 4'd0;
      #1 chk("R1 async clear count", int'(count), 0);
      set_clr(1'b1);
      set_clr(1'b0);
      expect_now("R1 after async clear");
      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule